// File: doc/BRIEF.md
# Processor Clock-Control Power State Controller

This block follows a processor core through its clock-control power states: Normal (code 0), Halt (code 1), Stop Grant (code 2), Stop Grant Inquire (code 3) and Stop Clock (code 4). It takes these inputs:

- a stop-clock request and a halt indication;
- a synchronous reset;
- a snoop address strobe, a snoop hit-on-modified-line flag and a writeback-done handshake;
- an indication that the input clock is running;
- five interrupt sources and an interrupt-enable flag.

The cache lookup, the bus writeback and the PLL are not part of this block. They appear only as these handshake inputs.

The named transitions are:

- **request-stop**: Normal to Stop Grant.
- **halt-enter**: Normal to Halt.
- **wake**: Halt to Normal.
- **resume**: Stop Grant to Normal.
- **snoop-enter**: Stop Grant or Halt to Stop Grant Inquire.
- **snoop-return**: Stop Grant Inquire back to the state it was entered from.
- **clock-gate**: Stop Grant to Stop Clock.
- **clock-restart**: Stop Clock to Stop Grant.
- **reset-return**: any state to Normal.

While clocks are gated in Stop Grant, the block stores interrupt events as pending flags and does not leave the state. It hands all stored flags to the core together on the first cycle back in Normal.

Top module: `clkctl_power_fsm`

## Requirements
- R1: With `rst` high at a clock edge, the next cycle shows `state_o` = 0 (Normal), `wb_req_o` = 0 and `svc_o` = 0.
- R2: In Normal, `stpclk_req` high moves the state to 2 (Stop Grant) at the next edge. Otherwise `halt_ind` high moves it to 1 (Halt). The stop-clock request takes priority over the halt indication.
- R3: In Halt, any of INIT, FLUSH, NMI or SMI high, or INTR high together with `intr_en`, moves the state to Normal at the next edge. INTR with `intr_en` low leaves the state in Halt.
- R4: In Stop Grant with `stpclk_req` high, no interrupt input causes an exit. When `stpclk_req` is seen low, the next state is Normal.
- R5: In Stop Grant, each of these is stored as a pending flag: a rising edge on INIT, FLUSH, NMI or SMI, and INTR high while `intr_en` is high. On the first cycle in Normal, `svc_o` shows the stored flags, with bit 0 = INIT, bit 1 = FLUSH, bit 2 = NMI, bit 3 = SMI and bit 4 = INTR. On the following cycle `svc_o` is 0 again.
- R6: A high `snoop_strb` in Stop Grant or in Halt moves the state to 3 (Stop Grant Inquire). On leaving that state, the controller returns to the state it was entered from.
- R7: If `snoop_hitm` is high in the cycle of the snoop strobe, `wb_req_o` is high for every cycle spent in Stop Grant Inquire. The state leaves Inquire at the edge where `wb_done` is seen. Without a modified hit, Inquire lasts exactly one cycle and `wb_req_o` stays low.
- R8: In Stop Grant with `stpclk_req` high, no snoop strobe and `clk_running` low, the next state is 4 (Stop Clock). A low `clk_running` in Halt leaves the state in Halt.
- R9: Stop Clock moves to Stop Grant when `clk_running` is seen high. INTR is not sampled in Stop Clock. It is first sampled on the first cycle back in Stop Grant.
- R10: Reset asserted in Stop Grant returns the state to Normal and discards every stored pending flag, so `svc_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stpclk_req | input | 1 | Stop-clock request |
| halt_ind | input | 1 | Core has executed a halt |
| snoop_strb | input | 1 | Snoop address strobe of an inquire cycle |
| snoop_hitm | input | 1 | Snoop hits a modified line (valid with the strobe) |
| wb_done | input | 1 | Writeback of the snooped line has completed |
| clk_running | input | 1 | High while the input clock is running |
| init_in | input | 1 | INIT interrupt source |
| intr_in | input | 1 | Maskable interrupt request (level) |
| flush_in | input | 1 | Cache flush request |
| nmi_in | input | 1 | Non-maskable interrupt |
| smi_in | input | 1 | System management interrupt |
| intr_en | input | 1 | Interrupt enable for INTR |
| state_o | output | 3 | Current state code (0 Normal, 1 Halt, 2 Stop Grant, 3 Inquire, 4 Stop Clock) |
| wb_req_o | output | 1 | Writeback request during a modified snoop hit |
| svc_o | output | 5 | Pending interrupts released on return to Normal |

## Verification
The bench builds the block with its default parameters: four edge-captured sources and one level source, stored in five pending bits. With these values every bit position of `svc_o` can be reached, and each state can be reached through each of its named transitions. Directed sequences drive both origins of an inquire, both with and without a modified hit. They also drive an INTR pulse that exists only during Stop Clock, to show that it is not captured, and a reset that discards pending events.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        PS_NORMAL  = 3'd0,
        PS_HALT    = 3'd1,
        PS_GRANT   = 3'd2,
        PS_INQ     = 3'd3,
        PS_STOPPED = 3'd4
    } pwr_state_e;

    localparam int EDGE_SRC_N = 4;
    localparam int PEND_W     = EDGE_SRC_N + 1;

    localparam int PB_INIT  = 0;
    localparam int PB_FLUSH = 1;
    localparam int PB_NMI   = 2;
    localparam int PB_SMI   = 3;
    localparam int PB_INTR  = 4;

endpackage

// File: rtl/clkctl_state_fsm.sv
module clkctl_state_fsm
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stpclk_req,
    input  logic       halt_ind,
    input  logic       snoop_strb,
    input  logic       snoop_hitm,
    input  logic       wb_done,
    input  logic       clk_running,
    input  logic       wake,
    output pwr_state_e state_q,
    output logic       wb_req
);

    pwr_state_e state_d;
    logic       from_halt_q, from_halt_d;
    logic       hitm_q, hitm_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= PS_NORMAL;
            from_halt_q <= 1'b0;
            hitm_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            from_halt_q <= from_halt_d;
            hitm_q      <= hitm_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        from_halt_d = from_halt_q;
        hitm_d      = hitm_q;
        unique case (state_q)
            PS_NORMAL: begin
                if (stpclk_req)     state_d = PS_GRANT;
                else if (halt_ind)  state_d = PS_HALT;
            end
            PS_HALT: begin
                if (wake) begin
                    state_d = PS_NORMAL;
                end else if (snoop_strb) begin
                    state_d     = PS_INQ;
                    from_halt_d = 1'b1;
                    hitm_d      = snoop_hitm;
                end
            end
            PS_GRANT: begin
                if (!stpclk_req) begin
                    state_d = PS_NORMAL;
                end else if (snoop_strb) begin
                    state_d     = PS_INQ;
                    from_halt_d = 1'b0;
                    hitm_d      = snoop_hitm;
                end else if (!clk_running) begin
                    state_d = PS_STOPPED;
                end
            end
            PS_INQ: begin
                if (!hitm_q || wb_done) begin
                    state_d = from_halt_q ? PS_HALT : PS_GRANT;
                    hitm_d  = 1'b0;
                end
            end
            PS_STOPPED: begin
                if (clk_running) state_d = PS_GRANT;
            end
            default: state_d = PS_NORMAL;
        endcase
    end

    always_comb begin
        wb_req = 1'b0;
        unique case (state_q)
            PS_INQ:  wb_req = hitm_q;
            default: wb_req = 1'b0;
        endcase
    end

    assert_halt_no_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_HALT) |=> (state_q != PS_STOPPED));

    assert_stopped_origin_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_GRANT && state_q != PS_STOPPED) |=> (state_q != PS_STOPPED));

    assert_grant_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_GRANT && stpclk_req) |=> (state_q != PS_NORMAL));

    assert_inq_return_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_INQ && !wb_req) |=> (state_q == PS_HALT || state_q == PS_GRANT));

    assert_wb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_done) |=> (wb_req && state_q == PS_INQ));

    assert_reset_normal_R1: assert property (@(posedge clk)
        rst |=> (state_q == PS_NORMAL && !wb_req));

endmodule

// File: rtl/clkctl_pend_latch.sv
module clkctl_pend_latch #(
    parameter int EDGE_N = 4,
    localparam int W     = EDGE_N + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              release_now,
    input  logic [EDGE_N-1:0] edge_in,
    input  logic              level_in,
    input  logic              level_en,
    output logic [W-1:0]      svc
);

    logic [EDGE_N-1:0] prev_q;
    logic [W-1:0]      pend_q;
    logic [W-1:0]      hit;

    for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= edge_in[g];
        end
        assign hit[g] = edge_in[g] & ~prev_q[g];
    end
    assign hit[EDGE_N] = level_in & level_en;

    always_ff @(posedge clk) begin
        if (rst)              pend_q <= '0;
        else if (release_now) pend_q <= '0;
        else if (capture)     pend_q <= pend_q | hit;
    end

    assign svc = release_now ? pend_q : '0;

    assert_svc_single_R5: assert property (@(posedge clk) disable iff (rst)
        (|svc) |=> !(|svc));

    assert_cleared_by_reset_R10: assert property (@(posedge clk)
        rst |=> (svc == '0));

endmodule

// File: rtl/clkctl_power_fsm.sv
module clkctl_power_fsm
    import clkctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                stpclk_req,
    input  logic                halt_ind,
    input  logic                snoop_strb,
    input  logic                snoop_hitm,
    input  logic                wb_done,
    input  logic                clk_running,
    input  logic                init_in,
    input  logic                intr_in,
    input  logic                flush_in,
    input  logic                nmi_in,
    input  logic                smi_in,
    input  logic                intr_en,
    output logic [2:0]          state_o,
    output logic                wb_req_o,
    output logic [PEND_W-1:0]   svc_o
);

    pwr_state_e            cur_state;
    logic [EDGE_SRC_N-1:0] edge_vec;
    logic                  wake;

    always_comb begin
        edge_vec           = '0;
        edge_vec[PB_INIT]  = init_in;
        edge_vec[PB_FLUSH] = flush_in;
        edge_vec[PB_NMI]   = nmi_in;
        edge_vec[PB_SMI]   = smi_in;
    end

    assign wake = (|edge_vec) | (intr_in & intr_en);

    clkctl_state_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .stpclk_req  (stpclk_req),
        .halt_ind    (halt_ind),
        .snoop_strb  (snoop_strb),
        .snoop_hitm  (snoop_hitm),
        .wb_done     (wb_done),
        .clk_running (clk_running),
        .wake        (wake),
        .state_q     (cur_state),
        .wb_req      (wb_req_o)
    );

    clkctl_pend_latch #(.EDGE_N(EDGE_SRC_N)) u_pend (
        .clk         (clk),
        .rst         (rst),
        .capture     (cur_state == PS_GRANT),
        .release_now (cur_state == PS_NORMAL),
        .edge_in     (edge_vec),
        .level_in    (intr_in),
        .level_en    (intr_en),
        .svc         (svc_o)
    );

    assign state_o = cur_state;

    assert_svc_in_normal_R5: assert property (@(posedge clk) disable iff (rst)
        (|svc_o) |-> (state_o == 3'd0));

    assert_wb_in_inq_R7: assert property (@(posedge clk) disable iff (rst)
        wb_req_o |-> (state_o == 3'd3));

endmodule

// File: tb/test_clkctl_power_fsm.sv
`timescale 1ns/1ps
module test_clkctl_power_fsm;

    logic       clk = 1'b0;
    logic       rst, stpclk_req, halt_ind, snoop_strb, snoop_hitm, wb_done;
    logic       clk_running, init_in, intr_in, flush_in, nmi_in, smi_in, intr_en;
    logic [2:0] state_o;
    logic       wb_req_o;
    logic [4:0] svc_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    clkctl_power_fsm i_clkctl_power_fsm (
        .clk(clk), .rst(rst), .stpclk_req(stpclk_req), .halt_ind(halt_ind),
        .snoop_strb(snoop_strb), .snoop_hitm(snoop_hitm), .wb_done(wb_done),
        .clk_running(clk_running), .init_in(init_in), .intr_in(intr_in),
        .flush_in(flush_in), .nmi_in(nmi_in), .smi_in(smi_in), .intr_en(intr_en),
        .state_o(state_o), .wb_req_o(wb_req_o), .svc_o(svc_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        stpclk_req = 0; halt_ind = 0; snoop_strb = 0; snoop_hitm = 0; wb_done = 0;
        clk_running = 1; init_in = 0; intr_in = 0; flush_in = 0; nmi_in = 0;
        smi_in = 0; intr_en = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1; step();
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(state_o, 0, "R1 state");
        chk(wb_req_o, 0, "R1 wb_req");
        chk(svc_o, 0, "R1 svc");
    endtask

    task automatic t_normal_halt();
        do_reset();
        halt_ind = 1; step();
        chk(state_o, 1, "R2 halt-enter");
        halt_ind = 0; intr_in = 1; intr_en = 0; step();
        chk(state_o, 1, "R3 masked INTR keeps Halt");
        intr_en = 1; step();
        chk(state_o, 0, "R3 wake on enabled INTR");
        intr_in = 0; intr_en = 0;
        stpclk_req = 1; halt_ind = 1; step();
        chk(state_o, 2, "R2 stop request priority");
        halt_ind = 0;
    endtask

    task automatic t_grant_latch();
        do_reset();
        stpclk_req = 1; step();
        nmi_in = 1; step();
        chk(state_o, 2, "R4 NMI does not exit");
        nmi_in = 0; smi_in = 1; step();
        chk(state_o, 2, "R4 SMI does not exit");
        smi_in = 0; intr_in = 1; intr_en = 0; step();
        intr_en = 1; step();
        intr_in = 0; intr_en = 0;
        chk(svc_o, 0, "R5 nothing released in Stop Grant");
        stpclk_req = 0; step();
        chk(state_o, 0, "R4 resume to Normal");
        chk(svc_o, 28, "R5 released flags");
        step();
        chk(svc_o, 0, "R5 single-cycle release");
    endtask

    task automatic t_inq_grant();
        do_reset();
        stpclk_req = 1; step();
        snoop_strb = 1; snoop_hitm = 0; step();
        chk(state_o, 3, "R6 snoop-enter from Stop Grant");
        chk(wb_req_o, 0, "R7 no wb on clean hit");
        snoop_strb = 0; step();
        chk(state_o, 2, "R6 return to Stop Grant");
        snoop_strb = 1; snoop_hitm = 1; step();
        chk(wb_req_o, 1, "R7 wb on modified hit");
        snoop_strb = 0; snoop_hitm = 0; step();
        chk(state_o, 3, "R7 wait for wb_done");
        chk(wb_req_o, 1, "R7 wb held");
        wb_done = 1; step();
        wb_done = 0;
        chk(state_o, 2, "R7 return after wb_done");
        chk(wb_req_o, 0, "R7 wb dropped");
    endtask

    task automatic t_inq_halt();
        do_reset();
        halt_ind = 1; step();
        halt_ind = 0; snoop_strb = 1; snoop_hitm = 1; step();
        chk(state_o, 3, "R6 snoop-enter from Halt");
        snoop_strb = 0; snoop_hitm = 0; wb_done = 1; step();
        wb_done = 0;
        chk(state_o, 1, "R6 return to Halt");
        clk_running = 0; step(); step();
        chk(state_o, 1, "R8 no Stop Clock from Halt");
        clk_running = 1;
    endtask

    task automatic t_stopclock();
        do_reset();
        stpclk_req = 1; step();
        clk_running = 0; step();
        chk(state_o, 4, "R8 clock-gate");
        intr_in = 1; intr_en = 1; step(); step();
        chk(state_o, 4, "R9 INTR does not leave Stop Clock");
        intr_in = 0; clk_running = 1; step();
        chk(state_o, 2, "R9 clock-restart");
        stpclk_req = 0; step();
        chk(svc_o, 0, "R9 INTR in Stop Clock not sampled");
        stpclk_req = 1; step();
        clk_running = 0; step();
        intr_in = 1; step();
        clk_running = 1; step();
        chk(state_o, 2, "R9 back in Stop Grant");
        step();
        intr_in = 0; intr_en = 0; stpclk_req = 0; step();
        chk(svc_o, 16, "R9 INTR sampled after return");
    endtask

    task automatic t_reset_grant();
        do_reset();
        stpclk_req = 1; step();
        init_in = 1; step();
        init_in = 0; flush_in = 1; step();
        flush_in = 0; rst = 1; step();
        rst = 0; stpclk_req = 0;
        chk(state_o, 0, "R10 reset-return");
        chk(svc_o, 0, "R10 pending discarded");
        step();
        chk(svc_o, 0, "R10 nothing released later");
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_normal_halt();
        t_grant_latch();
        t_inq_grant();
        t_inq_halt();
        t_stopclock();
        t_reset_grant();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule